// File: doc/BRIEF.md
# NAND Flash Bus Device Front-End

This block is the device-side logic behind an 8-bit asynchronous NAND flash bus. The host drives one shared byte bus and several strobes. On each write-strobe rising edge, the block routes the byte by the two latch-enable strobes. With the command strobe set, the byte goes to the command register. With the address strobe set, it goes to the next address byte. With neither set, it goes into a page buffer at the current column. Each falling edge of the read strobe puts the next buffer byte on the output and steps the column. When the last command was a status query, the read strobe returns a status byte instead.

The strobe pins are asynchronous. Each one, and the input bus, passes through a two-flop synchroniser on the system clock before any edge is detected. Program, erase and page-read starts are modelled by a busy timer. While the timer runs, the ready output is low, and only a status query is still accepted. Chip enable and the read strobe gate the output enable. Write protect blocks program and erase, and it cancels a program or erase that is already running.

The bus is a set of pins with no handshake. The host paces bytes by strobe timing, and the block never applies back-pressure. A byte written while the block is busy, other than a status query, is dropped and not queued. Each strobe level must be held for at least three system clocks.

Top module: `nand_bus_frontend`

## Requirements
- R1: With the command strobe high and the address strobe low, a write-strobe rising edge while selected and ready loads the bus byte into `cmd_q`.
- R2: Address bytes are counted from the last 0x00, 0x60 or 0x80 command. The first address byte sets the column, which is the byte modulo COLS. The next ADDR_BYTES-1 bytes fill `row_addr`, lowest byte first. Any further address bytes are ignored.
- R3: With both latch strobes low, a write-strobe rising edge stores the bus byte in the page buffer at the column and then increments the column.
- R4: Each read-strobe falling edge while selected drives the page-buffer byte at the column onto `io_out` and increments the column. The column wraps from COLS-1 to 0.
- R5: `io_oe` is high only while chip enable and the read strobe are both low, as seen after synchronisation. Otherwise it is low.
- R6: Each of the following starts a busy period, and `ready` is low for exactly that many clocks:
  - command 0x10 after 0x80 lasts PROG_CYC clocks;
  - command 0xD0 after 0x60 lasts ERASE_CYC clocks;
  - command 0x30 after 0x00 lasts READ_CYC clocks.
- R7: Raising chip enable during a busy period does not stop it or shorten it.
- R8: While write protect is low, 0x10 and 0xD0 start no busy period. Write protect going low during a program or erase ends that busy period within a few clocks.
- R9: While busy, writes to the command, address and data paths are ignored, with one exception: command 0x70 is accepted. After 0x70, read strobes return a status byte with bit7 = write protect pin, bit6 = ready, bit0 = error flag, and all other bits zero.
- R10: A write edge with both latch strobes high discards the byte, leaving `cmd_q`, `row_addr` and the buffer unchanged. It also sets `dual_err`, which stays set until reset.
- R11: After reset, `ready`=1, `dual_err`=0, `cmd_q`=0, `row_addr`=0 and `io_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| we_n | input | 1 | Write strobe, latched on its rising edge |
| re_n | input | 1 | Read strobe, output advances on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte bus from host |
| io_out | output | 8 | Byte bus to host |
| io_oe | output | 1 | Output enable for the bus driver |
| ready | output | 1 | High when idle, low during a busy period |
| cmd_q | output | 8 | Command register |
| row_addr | output | 8*(ADDR_BYTES-1) | Captured row address |
| dual_err | output | 1 | Sticky flag for a write with both latch strobes high |

## Verification
The assertions check these properties on every cycle:
- the error flag never clears;
- the output enable never rises unless chip enable was low two clocks earlier;
- a running timer keeps `ready` low;
- write protect forces `ready` high during a program or erase;
- the command and row registers stay frozen while busy, apart from a status query.

Some behaviours can only be shown by the bench's scenarios:
- the exact length of each busy period;
- column increment and wrap during reads;
- address bytes beyond the configured count being dropped;
- the bit layout of the status byte.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} op_e;
  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_LOAD     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
endpackage

// File: rtl/nand_fe_sync.sv
module nand_fe_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/nand_fe_timer.sv
module nand_fe_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  input  logic          abort,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (abort)        cnt <= '0;
    else if (start)        cnt <= load;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != '0);
endmodule

// File: rtl/nand_fe_pagebuf.sv
module nand_fe_pagebuf #(
  parameter int COLS = 16,
  localparam int AW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [COLS];
  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend
  import nand_fe_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int COLS       = 16,
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 60,
  parameter int READ_CYC   = 20,
  localparam int ROW_BYTES = ADDR_BYTES - 1,
  localparam int ROW_W     = 8 * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic             wp_n,
  input  logic [7:0]       io_in,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic             ready,
  output logic [7:0]       cmd_q,
  output logic [ROW_W-1:0] row_addr,
  output logic             dual_err
);
  localparam int CAW  = $clog2(COLS);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ?
                        ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC) :
                        ((ERASE_CYC > READ_CYC) ? ERASE_CYC : READ_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int ACW   = $clog2(ADDR_BYTES + 1);
  localparam int SW    = 14;

  // synchronised pins: {ce_n, we_n, re_n, wp_n, cle, ale, io[7:0]}
  logic [SW-1:0] pins_s;
  nand_fe_sync #(.W(SW), .RST_VAL(14'b1110_00_00000000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n, we_n, re_n, wp_n, cle, ale, io_in}),
    .q(pins_s)
  );
  logic ce_s, we_s, re_s, wp_s, cle_s, ale_s;
  logic [7:0] io_s;
  assign {ce_s, we_s, re_s, wp_s, cle_s, ale_s, io_s} = pins_s;

  logic we_d, re_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d <= 1'b1;
      re_d <= 1'b1;
    end else begin
      we_d <= we_s;
      re_d <= re_s;
    end
  end

  logic busy;
  logic [CNT_W-1:0] busy_cnt;
  op_e  op_q, tmr_op;
  logic tmr_start, tmr_abort;
  logic [CNT_W-1:0] tmr_load;

  logic we_rise, re_fall, accept, is_cmd, is_addr, is_data, status_pick;
  assign we_rise     = !ce_s && we_s && !we_d;
  assign re_fall     = !ce_s && !re_s && re_d;
  assign accept      = we_rise && !busy;
  assign is_cmd      = cle_s && !ale_s;
  assign is_addr     = ale_s && !cle_s;
  assign is_data     = !ale_s && !cle_s;
  assign status_pick = we_rise && is_cmd && (io_s == CMD_STATUS);

  // operation start decode
  always_comb begin
    tmr_op = OP_NONE;
    if (accept && is_cmd) begin
      if (io_s == CMD_PROG_GO && cmd_q == CMD_LOAD && wp_s)          tmr_op = OP_PROG;
      else if (io_s == CMD_ER_GO && cmd_q == CMD_ER_SETUP && wp_s)   tmr_op = OP_ERASE;
      else if (io_s == CMD_RD_GO && cmd_q == CMD_RD_SETUP)           tmr_op = OP_READ;
    end
    tmr_start = (tmr_op != OP_NONE);
    case (tmr_op)
      OP_PROG:  tmr_load = CNT_W'(PROG_CYC);
      OP_ERASE: tmr_load = CNT_W'(ERASE_CYC);
      default:  tmr_load = CNT_W'(READ_CYC);
    endcase
  end
  assign tmr_abort = !wp_s && busy && (op_q == OP_PROG || op_q == OP_ERASE);

  nand_fe_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load),
    .abort(tmr_abort), .busy(busy), .cnt(busy_cnt)
  );

  logic [CAW-1:0] col;
  logic [ACW-1:0] addr_cnt;
  logic           stat_mode;
  logic [7:0]     buf_rd;
  logic           buf_we;
  assign buf_we = accept && is_data;

  nand_fe_pagebuf #(.COLS(COLS)) u_buf (
    .clk(clk), .wr_en(buf_we), .waddr(col), .wdata(io_s),
    .raddr(col), .rdata(buf_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      row_addr  <= '0;
      dual_err  <= 1'b0;
      col       <= '0;
      addr_cnt  <= '0;
      stat_mode <= 1'b0;
      op_q      <= OP_NONE;
      io_out    <= '0;
    end else begin
      if (we_rise && cle_s && ale_s) dual_err <= 1'b1;
      if (tmr_start) op_q <= tmr_op;
      if (status_pick) begin
        cmd_q     <= io_s;
        stat_mode <= 1'b1;
      end else if (accept && is_cmd) begin
        cmd_q     <= io_s;
        stat_mode <= 1'b0;
        if (io_s == CMD_RD_SETUP || io_s == CMD_LOAD || io_s == CMD_ER_SETUP)
          addr_cnt <= '0;
      end
      if (accept && is_addr) begin
        if (addr_cnt == '0) col <= io_s[CAW-1:0];
        for (int k = 0; k < ROW_BYTES; k++) begin
          if (addr_cnt == ACW'(k + 1)) row_addr[k*8 +: 8] <= io_s;
        end
        if (addr_cnt < ACW'(ADDR_BYTES)) addr_cnt <= addr_cnt + 1'b1;
      end
      if (buf_we) col <= col + 1'b1;
      if (re_fall) begin
        if (stat_mode) begin
          io_out <= {wp_s, !busy, 5'b0, dual_err};
        end else if (!busy) begin
          io_out <= buf_rd;
          col    <= col + 1'b1;
        end
      end
    end
  end

  assign io_oe = !ce_s && !re_s;
  assign ready = !busy;
endmodule

// File: rtl/nand_bus_frontend_chk.sv
module nand_bus_frontend_chk
  import nand_fe_pkg::*;
#(
  parameter int CW = 6,
  parameter int RW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          io_oe,
  input logic          ready,
  input logic          dual_err,
  input logic [7:0]    cmd_q,
  input logic [RW-1:0] row_addr,
  input logic [CW-1:0] busy_cnt,
  input logic          wp_s,
  input logic          status_pick,
  input op_e           op_q
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dual_err) |-> dual_err); // R10

  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> !$past(ce_n, 2)); // R5

  AST_BUSY_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt > CW'(1) && wp_s) |=> !ready); // R7

  AST_WP_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_s && !ready && (op_q == OP_PROG || op_q == OP_ERASE)) |=> ready); // R8

  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(row_addr)); // R9

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !status_pick) |=> $stable(cmd_q)); // R9
endmodule

bind nand_bus_frontend nand_bus_frontend_chk #(.CW(CNT_W), .RW(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .io_oe(io_oe), .ready(ready),
  .dual_err(dual_err), .cmd_q(cmd_q), .row_addr(row_addr),
  .busy_cnt(busy_cnt), .wp_s(wp_s), .status_pick(status_pick), .op_q(op_q)
);

// File: tb/nand_bus_frontend_tb.sv
module nand_bus_frontend_tb;
  localparam int PROG_CYC = 40, ERASE_CYC = 60, READ_CYC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = '0;
  logic [7:0] io_out, cmd_q;
  logic [23:0] row_addr;
  logic io_oe, ready, dual_err;

  int total = 0, bad = 0;
  int exp_busy[$];
  int low_cnt = 0;

  always #4 clk = ~clk;

  nand_bus_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .ready(ready), .cmd_q(cmd_q), .row_addr(row_addr), .dual_err(dual_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic c, logic a, logic [7:0] b);
    @(negedge clk);
    ce_n = 1'b0; cle = c; ale = a; io_in = b; we_n = 1'b0;
    hold(4);
    we_n = 1'b1;
    hold(4);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] b, output logic oe);
    @(negedge clk);
    ce_n = 1'b0; re_n = 1'b0;
    hold(4);
    b = io_out; oe = io_oe;
    re_n = 1'b1;
    hold(4);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
    hold(2);
  endtask

  // scoreboard monitor: compares each busy length with the queued expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ready) low_cnt++;
      else if (low_cnt != 0) begin
        total++;
        if (exp_busy.size() == 0) begin
          bad++;
          $display("FAIL R6 actual=%0d expected=no busy period", low_cnt);
        end else begin
          automatic int e = exp_busy.pop_front();
          if (e != 0 && e != low_cnt) begin
            bad++;
            $display("FAIL R6 actual=%0d expected=%0d", low_cnt, e);
          end
        end
        low_cnt = 0;
      end
    end
  end

  initial begin
    hold(200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic oe;
    hold(3);
    rst_n = 1'b1;
    hold(2);
    // R11 reset state
    check("R11 ready", ready, 1);
    check("R11 err", dual_err, 0);
    check("R11 cmd", cmd_q, 0);
    check("R11 row", row_addr, 0);
    check("R11 oe", io_oe, 0);

    // R1 command capture
    bus_write(1, 0, 8'h80);
    check("R1 cmd", cmd_q, 8'h80);
    // R2 column 3, rows AA BB CC, extra byte dropped
    bus_write(0, 1, 8'h03);
    bus_write(0, 1, 8'hAA);
    bus_write(0, 1, 8'hBB);
    bus_write(0, 1, 8'hCC);
    bus_write(0, 1, 8'h55);
    check("R2 row", row_addr, 24'hCCBBAA);
    // R3 data into buffer at columns 3..6, plus columns 7..15 and wrap 0
    bus_write(0, 0, 8'h11);
    bus_write(0, 0, 8'h22);
    bus_write(0, 0, 8'h33);
    bus_write(0, 0, 8'h44);
    for (int i = 7; i < 17; i++) bus_write(0, 0, 8'(8'hA0 + i));

    // R6 program with R7 chip-enable release and R9 status during busy
    exp_busy.push_back(PROG_CYC);
    bus_write(1, 0, 8'h10);
    check("R6 prog busy", ready, 0);
    ce_n = 1'b1;
    hold(8);
    check("R7 busy with ce high", ready, 0);
    check("R5 oe deselected", io_oe, 0);
    bus_write(1, 0, 8'h00);
    check("R9 cmd ignored busy", cmd_q, 8'h10);
    bus_write(1, 0, 8'h70);
    check("R9 status accepted", cmd_q, 8'h70);
    bus_read(rb, oe);
    check("R9 status busy", rb, 8'h80);
    check("R5 oe on read", oe, 1);
    wait_ready();
    bus_read(rb, oe);
    check("R9 status ready", rb, 8'hC0);

    // R6 erase length
    exp_busy.push_back(ERASE_CYC);
    bus_write(1, 0, 8'h60);
    bus_write(0, 1, 8'h00);
    bus_write(0, 1, 8'h01);
    bus_write(0, 1, 8'h02);
    bus_write(0, 1, 8'h03);
    bus_write(1, 0, 8'hD0);
    wait_ready();
    check("R2 row erase", row_addr, 24'h030201);

    // R6 read, then R4 sequential read-out from column 3
    exp_busy.push_back(READ_CYC);
    bus_write(1, 0, 8'h00);
    bus_write(0, 1, 8'h03);
    bus_write(0, 1, 8'h00);
    bus_write(0, 1, 8'h00);
    bus_write(0, 1, 8'h00);
    bus_write(1, 0, 8'h30);
    wait_ready();
    bus_read(rb, oe); check("R4 byte0", rb, 8'h11);
    bus_read(rb, oe); check("R4 byte1", rb, 8'h22);
    bus_read(rb, oe); check("R4 byte2", rb, 8'h33);
    bus_read(rb, oe); check("R4 byte3", rb, 8'h44);
    check("R5 oe released", io_oe, 0);
    for (int i = 7; i < 16; i++) bus_read(rb, oe);
    check("R4 last col", rb, 8'hAF);
    bus_read(rb, oe); check("R4 wrap", rb, 8'hB0);

    // R8 write protect blocks program
    wp_n = 1'b0;
    bus_write(1, 0, 8'h80);
    bus_write(1, 0, 8'h10);
    hold(10);
    check("R8 blocked", ready, 1);
    // R8 write protect cancels running program
    wp_n = 1'b1;
    hold(4);
    exp_busy.push_back(0);
    bus_write(1, 0, 8'h80);
    bus_write(1, 0, 8'h10);
    wp_n = 1'b0;
    hold(6);
    check("R8 cancelled", ready, 1);
    wp_n = 1'b1;
    hold(4);

    // R10 both strobes high
    bus_write(1, 0, 8'h00);
    bus_write(1, 1, 8'h5A);
    check("R10 err set", dual_err, 1);
    check("R10 cmd kept", cmd_q, 8'h00);
    check("R10 row kept", row_addr, 24'h000000);
    bus_write(1, 0, 8'h70);
    bus_read(rb, oe);
    check("R10 status err bit", rb, 8'hC1);
    ce_n = 1'b1;
    hold(4);
    check("R10 sticky", dual_err, 1);
    check("R6 queue drained", exp_busy.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule